// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Unit

This block gathers every interrupt cause of one UART channel and turns them into a single active-low interrupt request plus a 6-bit identification code that software reads to learn which cause to service. It takes status from the receiver, the transmitter, the flow-control character detector and the modem/handshake pins. It also takes the access strobes of the register file: identification read, receive-holding read, transmit-holding write, line-status read and modem-status read. Each cause is held or followed according to its own clear rule. An eight-bit enable word masks each cause. A fixed priority order then picks the one cause to report.

Event causes are pulses: overrun, receive time-out, transmit-ready, modem change, Xoff, Xon and special character. The block latches them into sticky flags. Level causes are followed directly: errored characters still in the receive FIFO, and receive data available. Rising edges of the two active-low handshake pins are detected inside the block. The code is a combinational function of the flags, the levels and the enable word. A clear triggered by an identification read therefore acts only on the cause that the code shows in that same cycle.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, `int_id` is 6'b000001 and `irq_n` is 1.
- R2: The line-status cause reports 6'b000110 and has the highest priority. It is pending while `rx_err_lvl` is 1, or after an `rx_ovr_pulse` until the next `lsr_rd`. An `lsr_rd` has no effect on the level part.
- R3: A receive time-out (`rx_tout_pulse`) reports 6'b001100 and stays pending until `rhr_rd`. Data ready (`rx_ready` level) reports 6'b000100. Both share priority level 2 and need enable bit 0, and the time-out wins over data ready.
- R4: A transmit-ready event (`thr_evt`) reports 6'b000010 at level 3, needs enable bit 1, and clears on `thr_wr` or on an `iir_rd` while 6'b000010 is shown.
- R5: A pulse on any bit of `msr_chg` reports 6'b000000 at level 4, needs enable bit 3, and clears on `msr_rd`.
- R6: `xoff_det` or `spec_det` reports 6'b010000 at level 5 and needs enable bit 5. An Xoff cause clears only on `xon_det`, and an identification read does not clear it. A special-character cause clears on an `iir_rd` while 6'b010000 is shown.
- R7: A low-to-high transition of `rts_n` (enable bit 6) or `cts_n` (enable bit 7) reports 6'b100000 at level 6. It clears on an `iir_rd` while 6'b100000 is shown. A high-to-low transition raises nothing.
- R8: Each cause takes part only while its enable bit is 1. Enable bit 4 has no effect. With enable bits 3:0 and 7:5 all 0, `irq_n` stays 1 and `int_id` stays 6'b000001.
- R9: `irq_n` is 0 exactly when `int_id` bit 0 is 0.
- R10: An `iir_rd` clears only the cause whose code is shown in that cycle. Lower-priority pending causes keep their flags.
- R11: When a cause's set event and its clear strobe arrive in the same cycle, the cause remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier | input | 8 | Enable word: bit0 receive data/time-out, bit1 transmit, bit2 line status, bit3 modem, bit5 Xoff/special, bit6 RTS, bit7 CTS |
| rx_err_lvl | input | 1 | 1 while any errored character sits in the receive FIFO |
| rx_ovr_pulse | input | 1 | One-cycle overrun event |
| rx_tout_pulse | input | 1 | One-cycle receive time-out event |
| rx_ready | input | 1 | Receive data available / above trigger level |
| thr_evt | input | 1 | One-cycle transmit-ready event |
| msr_chg | input | 4 | One-cycle modem change events |
| xoff_det | input | 1 | Xoff character detected |
| xon_det | input | 1 | Xon character detected |
| spec_det | input | 1 | Special character detected |
| rts_n | input | 1 | RTS pin, active low, synchronous |
| cts_n | input | 1 | CTS pin, active low, synchronous |
| iir_rd | input | 1 | Identification register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| int_id | output | 6 | Identification code of the reported cause |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Several properties are checked on every cycle. The request line must agree with bit 0 of the code. A fully disabled enable word must keep the line inactive. An enabled error level must always win. Enabled receive data must never be hidden behind a lower-priority code. A transmit write must remove the transmit code, and a modem-status read must remove the modem code, one cycle later. The bench alone can show the priority order over every combination of pending causes, the full masking table over all 256 enable words, the sticky and clear rules of each cause, which causes an identification read leaves alone, and set-over-clear collisions.

// File: rtl/uirq_pkg.sv
// Package: shared constants for the UART interrupt identification unit.
// Holds the cause indices (lowest index = highest priority) and the
// identification codes; assumes exactly seven reportable causes.
package uirq_pkg;
    localparam int ID_W  = 6;
    localparam int N_SRC = 7;

    // Cause indices in priority order
    localparam int S_LS  = 0;
    localparam int S_TO  = 1;
    localparam int S_RDY = 2;
    localparam int S_THR = 3;
    localparam int S_MS  = 4;
    localparam int S_XO  = 5;
    localparam int S_CR  = 6;

    localparam logic [ID_W-1:0] ID_NONE = 6'b000001;
    localparam logic [ID_W-1:0] ID_LS   = 6'b000110;
    localparam logic [ID_W-1:0] ID_TO   = 6'b001100;
    localparam logic [ID_W-1:0] ID_RDY  = 6'b000100;
    localparam logic [ID_W-1:0] ID_THR  = 6'b000010;
    localparam logic [ID_W-1:0] ID_MS   = 6'b000000;
    localparam logic [ID_W-1:0] ID_XO   = 6'b010000;
    localparam logic [ID_W-1:0] ID_CR   = 6'b100000;

    // Map a cause index to its identification code
    function automatic logic [ID_W-1:0] id_of(input int idx);
        case (idx)
            S_LS:    return ID_LS;
            S_TO:    return ID_TO;
            S_RDY:   return ID_RDY;
            S_THR:   return ID_THR;
            S_MS:    return ID_MS;
            S_XO:    return ID_XO;
            S_CR:    return ID_CR;
            default: return ID_NONE;
        endcase
    endfunction
endpackage

// File: rtl/uirq_sticky.sv
// Module: bank of W set/clear flags.
// Each bit is set by its set input and cleared by its clear input; a set
// arriving with a clear in the same cycle wins. Synchronous active-low reset.
module uirq_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // Update every flag: hold, clear, or set (set dominant)
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/uirq_rise_det.sv
// Module: low-to-high transition detector for W synchronous pins.
// Assumes pins are already synchronised to clk. The previous value resets
// to 1 (inactive), so no event is reported straight out of reset.
module uirq_rise_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    // Remember last cycle's pin value
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= pin;
    end

    // Flag each pin that is high now and was low before
    always_comb rise = pin & ~prev;
endmodule

// File: rtl/uirq_prio_enc.sv
// Module: fixed-priority selector for masked interrupt requests.
// Request index 0 has the highest priority. Produces a one-hot grant, the
// identification code of the granted cause, and an any-pending flag.
module uirq_prio_enc
    import uirq_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic [N-1:0]    req,
    output logic [N-1:0]    grant,
    output logic [ID_W-1:0] code,
    output logic            any
);
    // Scan from lowest to highest priority so the highest pending is kept
    always_comb begin
        grant = '0;
        code  = ID_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                code     = id_of(i);
            end
        end
    end

    // Any pending request at all
    always_comb any = |req;
endmodule

// File: rtl/uart_irq_prio.sv
// Module: UART interrupt identification unit (top).
// Latches event causes into sticky flags, follows level causes directly,
// masks with the enable word and reports the highest-priority cause as a
// code plus an active-low request. Assumes all inputs are synchronous to
// clk and strobes are one cycle wide per register access.
module uart_irq_prio
    import uirq_pkg::*;
#(
    parameter int MS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      ier,
    input  logic            rx_err_lvl,
    input  logic            rx_ovr_pulse,
    input  logic            rx_tout_pulse,
    input  logic            rx_ready,
    input  logic            thr_evt,
    input  logic [MS_W-1:0] msr_chg,
    input  logic            xoff_det,
    input  logic            xon_det,
    input  logic            spec_det,
    input  logic            rts_n,
    input  logic            cts_n,
    input  logic            iir_rd,
    input  logic            rhr_rd,
    input  logic            thr_wr,
    input  logic            lsr_rd,
    input  logic            msr_rd,
    output logic [ID_W-1:0] int_id,
    output logic            irq_n
);
    // Flag positions inside the sticky bank
    localparam int F_OVR  = 0;
    localparam int F_TO   = 1;
    localparam int F_THR  = 2;
    localparam int F_XOFF = 3;
    localparam int F_SPEC = 4;
    localparam int F_RTS  = 5;
    localparam int F_CTS  = 6;
    localparam int F_MS0  = 7;
    localparam int NF     = F_MS0 + MS_W;

    logic [NF-1:0]    f_set, f_clr, flag;
    logic [1:0]       pin_rise;
    logic [N_SRC-1:0] req, grant;
    logic             any_req;
    logic             unused_ier4;

    assign unused_ier4 = ier[4];

    uirq_rise_det #(.W(2)) u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({cts_n, rts_n}),
        .rise (pin_rise)
    );

    // Route event pulses to flag set inputs
    always_comb begin
        f_set                          = '0;
        f_set[F_OVR]                   = rx_ovr_pulse;
        f_set[F_TO]                    = rx_tout_pulse;
        f_set[F_THR]                   = thr_evt;
        f_set[F_XOFF]                  = xoff_det;
        f_set[F_SPEC]                  = spec_det;
        f_set[F_RTS]                   = pin_rise[0];
        f_set[F_CTS]                   = pin_rise[1];
        f_set[F_MS0 +: MS_W]           = msr_chg;
    end

    // Route register strobes to flag clear inputs; identification reads
    // act only on the cause granted in the same cycle
    always_comb begin
        f_clr                = '0;
        f_clr[F_OVR]         = lsr_rd;
        f_clr[F_TO]          = rhr_rd;
        f_clr[F_THR]         = thr_wr | (iir_rd & grant[S_THR]);
        f_clr[F_XOFF]        = xon_det;
        f_clr[F_SPEC]        = iir_rd & grant[S_XO];
        f_clr[F_RTS]         = iir_rd & grant[S_CR];
        f_clr[F_CTS]         = iir_rd & grant[S_CR];
        f_clr[F_MS0 +: MS_W] = {MS_W{msr_rd}};
    end

    uirq_sticky #(.W(NF)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (f_set),
        .clr  (f_clr),
        .q    (flag)
    );

    // Combine flags and levels with the enable word into masked requests
    always_comb begin
        req        = '0;
        req[S_LS]  = ier[2] & (rx_err_lvl | flag[F_OVR]);
        req[S_TO]  = ier[0] & flag[F_TO];
        req[S_RDY] = ier[0] & rx_ready;
        req[S_THR] = ier[1] & flag[F_THR];
        req[S_MS]  = ier[3] & (|flag[F_MS0 +: MS_W]);
        req[S_XO]  = ier[5] & (flag[F_XOFF] | flag[F_SPEC]);
        req[S_CR]  = (ier[6] & flag[F_RTS]) | (ier[7] & flag[F_CTS]);
    end

    uirq_prio_enc #(.N(N_SRC)) u_enc (
        .req  (req),
        .grant(grant),
        .code (int_id),
        .any  (any_req)
    );

    // Drive the active-low request line
    always_comb irq_n = ~any_req;
endmodule

// File: rtl/uirq_checker.sv
// Module: assertion checker for uart_irq_prio, attached with bind.
// Observes ports only; assumes the synchronous active-low reset of the top.
module uirq_checker #(
    parameter int MS_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      ier,
    input logic            rx_err_lvl,
    input logic            rx_ready,
    input logic            thr_evt,
    input logic            thr_wr,
    input logic [MS_W-1:0] msr_chg,
    input logic            msr_rd,
    input logic [5:0]      int_id,
    input logic            irq_n
);
    // R9: request line agrees with code bit 0
    a_r9_irq_vs_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == int_id[0]);

    // R1: bit 0 set means the idle code exactly
    a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        int_id[0] |-> int_id == 6'b000001);

    // R8: fully disabled enable word keeps the request inactive
    a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[3:0] == 4'b0 && ier[7:5] == 3'b0) |-> irq_n);

    // R2: an enabled error level always wins
    a_r2_ls_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[2] && rx_err_lvl) |-> int_id == 6'b000110);

    // R3: enabled receive data is never hidden by a lower-priority code
    a_r3_rx_level2: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[0] && rx_ready) |->
        (int_id == 6'b000110 || int_id == 6'b001100 || int_id == 6'b000100));

    // R4: a transmit write removes the transmit code
    a_r4_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_evt) |=> int_id != 6'b000010);

    // R5: a modem-status read removes the modem code
    a_r5_msr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && msr_chg == '0) |=> int_id != 6'b000000);
endmodule

bind uart_irq_prio uirq_checker #(.MS_W(MS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier       (ier),
    .rx_err_lvl(rx_err_lvl),
    .rx_ready  (rx_ready),
    .thr_evt   (thr_evt),
    .thr_wr    (thr_wr),
    .msr_chg   (msr_chg),
    .msr_rd    (msr_rd),
    .int_id    (int_id),
    .irq_n     (irq_n)
);

// File: tb/tb_uart_irq_prio.sv
module tb_uart_irq_prio;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] ier;
    logic       rx_err_lvl, rx_ovr_pulse, rx_tout_pulse, rx_ready, thr_evt;
    logic [3:0] msr_chg;
    logic       xoff_det, xon_det, spec_det, rts_n, cts_n;
    logic       iir_rd, rhr_rd, thr_wr, lsr_rd, msr_rd;
    logic [5:0] int_id;
    logic       irq_n;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 0;

    always #5 clk = ~clk;

    uart_irq_prio dut (
        .clk(clk), .rst_n(rst_n), .ier(ier),
        .rx_err_lvl(rx_err_lvl), .rx_ovr_pulse(rx_ovr_pulse),
        .rx_tout_pulse(rx_tout_pulse), .rx_ready(rx_ready),
        .thr_evt(thr_evt), .msr_chg(msr_chg),
        .xoff_det(xoff_det), .xon_det(xon_det), .spec_det(spec_det),
        .rts_n(rts_n), .cts_n(cts_n),
        .iir_rd(iir_rd), .rhr_rd(rhr_rd), .thr_wr(thr_wr),
        .lsr_rd(lsr_rd), .msr_rd(msr_rd),
        .int_id(int_id), .irq_n(irq_n)
    );

    // Expected code: pend bit0 LS, 1 TO, 2 RDY, 3 THR, 4 MS, 5 XO, 6 CTS
    function automatic logic [5:0] exp_code(input logic [6:0] p, input logic [7:0] e);
        if      (p[0] && e[2]) return 6'b000110;
        else if (p[1] && e[0]) return 6'b001100;
        else if (p[2] && e[0]) return 6'b000100;
        else if (p[3] && e[1]) return 6'b000010;
        else if (p[4] && e[3]) return 6'b000000;
        else if (p[5] && e[5]) return 6'b010000;
        else if (p[6] && e[7]) return 6'b100000;
        else                   return 6'b000001;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [5:0] exp);
        n_chk++;
        if (int_id !== exp || irq_n !== exp[0]) begin
            n_err++;
            $display("FAIL %s: int_id=%b irq_n=%b expected int_id=%b irq_n=%b",
                     req, int_id, irq_n, exp, exp[0]);
        end
    endtask

    task automatic idle_inputs();
        rx_err_lvl = 0; rx_ovr_pulse = 0; rx_tout_pulse = 0; rx_ready = 0;
        thr_evt = 0; msr_chg = '0; xoff_det = 0; xon_det = 0; spec_det = 0;
        rts_n = 1; cts_n = 1;
        iir_rd = 0; rhr_rd = 0; thr_wr = 0; lsr_rd = 0; msr_rd = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; idle_inputs();
        step();
        rst_n = 1;
    endtask

    // Raise the causes in pattern p, leaving levels in place
    task automatic raise(input logic [6:0] p);
        rx_err_lvl = p[0]; rx_tout_pulse = p[1]; rx_ready = p[2];
        thr_evt = p[3]; msr_chg[0] = p[4]; xoff_det = p[5];
        if (p[6]) cts_n = 0;
        step();
        rx_tout_pulse = 0; thr_evt = 0; msr_chg = '0; xoff_det = 0; cts_n = 1;
        step();
    endtask

    initial begin
        ier = 8'hEF;
        do_reset();
        @(negedge clk);
        chk("R1 reset idle", 6'b000001);

        // R2 overrun sticky until LSR read
        rx_ovr_pulse = 1; step(); rx_ovr_pulse = 0;
        chk("R2 overrun", 6'b000110);
        lsr_rd = 1; step(); lsr_rd = 0;
        chk("R2 overrun cleared by lsr read", 6'b000001);
        rx_err_lvl = 1; step();
        lsr_rd = 1; step(); lsr_rd = 0;
        chk("R2 error level survives lsr read", 6'b000110);
        rx_err_lvl = 0; #1;
        chk("R2 error level gone", 6'b000001);

        // R3 time-out over data ready, read clears time-out
        rx_ready = 1; rx_tout_pulse = 1; step(); rx_tout_pulse = 0;
        chk("R3 time-out wins", 6'b001100);
        rhr_rd = 1; step(); rhr_rd = 0;
        chk("R3 data ready after rhr read", 6'b000100);
        rx_ready = 0; #1;
        chk("R3 no data", 6'b000001);

        // R4 transmit event cleared by iir read or thr write
        thr_evt = 1; step(); thr_evt = 0;
        chk("R4 thr", 6'b000010);
        iir_rd = 1; step(); iir_rd = 0;
        chk("R4 cleared by iir read", 6'b000001);
        thr_evt = 1; step(); thr_evt = 0;
        thr_wr = 1; step(); thr_wr = 0;
        chk("R4 cleared by thr write", 6'b000001);

        // R11 set beats clear in the same cycle
        thr_evt = 1; thr_wr = 1; step(); thr_evt = 0; thr_wr = 0;
        chk("R11 set wins over write", 6'b000010);
        thr_wr = 1; step(); thr_wr = 0;

        // R5 modem change on a high bit, cleared by msr read
        msr_chg = 4'b0100; step(); msr_chg = '0;
        chk("R5 modem", 6'b000000);
        msr_rd = 1; step(); msr_rd = 0;
        chk("R5 cleared by msr read", 6'b000001);

        // R6 Xoff needs Xon; special char cleared by iir read
        xoff_det = 1; step(); xoff_det = 0;
        chk("R6 xoff", 6'b010000);
        iir_rd = 1; step(); iir_rd = 0;
        chk("R6 xoff ignores iir read", 6'b010000);
        xon_det = 1; step(); xon_det = 0;
        chk("R6 xon clears", 6'b000001);
        spec_det = 1; step(); spec_det = 0;
        chk("R6 special", 6'b010000);
        iir_rd = 1; step(); iir_rd = 0;
        chk("R6 special cleared by iir read", 6'b000001);

        // R7 RTS rising edge, falling edge ignored
        rts_n = 0; step(); chk("R7 falling edge raises nothing", 6'b000001);
        rts_n = 1; step();
        chk("R7 rts rise", 6'b100000);
        iir_rd = 1; step(); iir_rd = 0;
        chk("R7 cleared by iir read", 6'b000001);

        // R10 iir read clears only the shown cause
        thr_evt = 1; rx_ovr_pulse = 1; step(); thr_evt = 0; rx_ovr_pulse = 0;
        chk("R10 line status shown first", 6'b000110);
        iir_rd = 1; step(); iir_rd = 0;
        lsr_rd = 1; step(); lsr_rd = 0;
        chk("R10 thr kept after iir read", 6'b000010);
        thr_wr = 1; step(); thr_wr = 0;

        // R8 enable bit 4 alone masks everything
        ier = 8'h10; thr_evt = 1; step(); thr_evt = 0;
        chk("R8 bit4 has no effect", 6'b000001);
        ier = 8'hEF; #1;
        chk("R8 flag kept while masked", 6'b000010);

        // Priority sweep over all 128 pending patterns, all enabled
        for (int s = 0; s < 128; s++) begin
            do_reset();
            raise(s[6:0]);
            chk("R2 R3 R4 R5 R6 R7 R9 priority sweep", exp_code(s[6:0], 8'hEF));
        end

        // Mask sweep over all 256 enable words, all causes pending
        do_reset();
        raise(7'h7F);
        for (int e = 0; e < 256; e++) begin
            ier = e[7:0]; #1;
            chk("R8 R9 mask sweep", exp_code(7'h7F, e[7:0]));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog R1: expired expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule